// File: doc/BRIEF.md
# Fractal Code SAD Search Engine

The engine turns one 4x4 block of luminance pixels into a fractal code. It takes the sixteen pixels in a single cycle and works out their mean, which becomes the code's offset. It subtracts that mean from every pixel. It then reads a codebook one entry per cycle through a synchronous RAM port. Each entry is compared against the mean-removed block under eight signed fractional scale factors at once. The error for each scale is a 16-lane sum of absolute differences, and the engine keeps the candidate with the smallest error seen so far.

When the last entry has been scored, a one-cycle completion pulse presents three values: the winning entry index, the winning scale code and the offset. The engine takes a new block only after that pulse. Codebook construction and any host-side control sit outside this block.

Top module: `fractal_sad_search`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: `out_offset` equals the sum of the sixteen unsigned 8-bit pixels shifted right by 4. Pixel i is `in_pix[8i+7:8i]`.
- R3: Matching uses the region with the offset subtracted from each pixel, as a 9-bit signed value. Region lane i is compared with codebook lane i, `cb_rdata[9i+8:9i]`, which is 9-bit two's complement.
- R4: Scale codes 0 to 7 stand for 1, 0.75, 0.5, 0.25, -0.25, -0.5, -0.75 and -1. Each scaled codebook value is truncated toward zero.
- R5: A candidate's error is the sum over the 16 lanes of |scaled codebook value - region value|. The error saturates at 4095.
- R6: The best error starts at 8192 for each region. A candidate replaces the best only when its error is strictly smaller, so a tie goes to the lower entry index and then to the lower scale code.
- R7: `n_entries` is sampled when a region is accepted. Entries 0 to n-1 are read in ascending order with `cb_en` high, one per cycle. Read data is expected one cycle after the address.
- R8: When `n_entries` is 0, the result is `out_idx` all ones (-1) and `out_scale` 4'hF (-1), meaning no match.
- R9: `out_valid` lasts exactly one cycle. `in_ready` is low from acceptance until after that pulse, and `in_valid` is ignored during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Region pixels valid |
| in_ready | output | 1 | Engine idle, ready to accept a region |
| in_pix | input | 128 | Sixteen 8-bit region pixels |
| n_entries | input | 11 | Number of codebook entries to search (0..1024) |
| cb_en | output | 1 | Codebook read enable |
| cb_addr | output | 10 | Codebook read address |
| cb_rdata | input | 144 | Codebook entry, sixteen 9-bit signed lanes, one cycle after address |
| out_valid | output | 1 | One-cycle result pulse |
| out_idx | output | 11 | Best entry index, all ones for none |
| out_scale | output | 4 | Best scale code 0..7, 4'hF for none |
| out_offset | output | 8 | Region mean |

## Verification
The assertions check the protocol shape on every cycle:
- the result pulse lasts one cycle and returns the engine to ready;
- no read is issued while idle;
- reads start at address zero and step by one;
- the index and scale agree on whether a match exists.

The arithmetic can only be shown through the bench's scenarios. That covers truncation toward zero on negative products, saturation, the tie-break order, the full 1024-entry sweep and the refusal of new pixels while busy. The bench compares each of these against a reference computed in its own functions.

// File: rtl/fractal_sad_search.sv
module fractal_sad_search #(
  parameter int ADDR_W = 10,
  parameter int NPIX   = 16,
  parameter int PIX_W  = 8,
  parameter int DW     = 9,
  parameter int ERR_W  = 12,
  parameter int NSCALE = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [NPIX*PIX_W-1:0]   in_pix,
  input  logic [ADDR_W:0]         n_entries,
  output logic                    cb_en,
  output logic [ADDR_W-1:0]       cb_addr,
  input  logic [NPIX*DW-1:0]      cb_rdata,
  output logic                    out_valid,
  output logic [ADDR_W:0]         out_idx,
  output logic [3:0]              out_scale,
  output logic [PIX_W-1:0]        out_offset
);
  localparam int SHIFT    = $clog2(NPIX);
  localparam int SUM_W    = PIX_W + SHIFT;
  localparam int AD_W     = DW + 2;
  localparam int ACC_W    = AD_W + SHIFT;
  localparam int ERR_INIT = NPIX * (1 << PIX_W) * 2;
  localparam int BW       = $clog2(ERR_INIT + 1);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_t;
  state_t state;

  logic [NPIX-1:0][DW-1:0] reg_r;
  logic [PIX_W-1:0]        off_q;
  logic [ADDR_W:0]         n_q, cnt;
  logic                    rd_vld, rd_last;
  logic [ADDR_W-1:0]       rd_idx;
  logic [BW-1:0]           best_err;
  logic [ADDR_W:0]         best_idx;
  logic [3:0]              best_sc;

  logic [SUM_W-1:0] pix_sum;
  always_comb begin
    pix_sum = '0;
    for (int i = 0; i < NPIX; i++)
      pix_sum = pix_sum + SUM_W'(in_pix[i*PIX_W +: PIX_W]);
  end
  wire [PIX_W-1:0] off_d = pix_sum[SUM_W-1 -: PIX_W];

  function automatic logic signed [DW:0] scale_val(input logic [DW-1:0] d, input logic [2:0] s);
    logic [2:0]      k;
    logic [DW-1:0]   mag_d;
    logic [DW+2:0]   prod;
    logic [DW:0]     m;
    k     = s[2] ? (s - 3'd3) : (3'd4 - s);
    mag_d = d[DW-1] ? (~d + 1'b1) : d;
    prod  = (DW+3)'(mag_d) * (DW+3)'(k);
    m     = prod[DW+2:2];
    return (d[DW-1] ^ s[2]) ? -$signed(m) : $signed(m);
  endfunction

  function automatic logic [AD_W-1:0] abs_diff(input logic signed [DW:0] sd, input logic [DW-1:0] r);
    logic signed [AD_W-1:0] df;
    df = AD_W'(sd) - AD_W'($signed(r));
    return df[AD_W-1] ? AD_W'(-df) : AD_W'(df);
  endfunction

  logic [ERR_W-1:0] sad [NSCALE];

  for (genvar gs = 0; gs < NSCALE; gs++) begin : g_sc
    logic [ACC_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int i = 0; i < NPIX; i++)
        acc = acc + ACC_W'(abs_diff(scale_val(cb_rdata[i*DW +: DW], 3'(gs)), reg_r[i]));
    end
    assign sad[gs] = (acc > ACC_W'(ERR_MAX)) ? ERR_MAX : acc[ERR_W-1:0];
  end

  logic [BW-1:0]   run_err;
  logic [ADDR_W:0] run_idx;
  logic [3:0]      run_sc;
  always_comb begin
    run_err = best_err;
    run_idx = best_idx;
    run_sc  = best_sc;
    for (int s = 0; s < NSCALE; s++) begin
      if (BW'(sad[s]) < run_err) begin
        run_err = BW'(sad[s]);
        run_idx = {1'b0, rd_idx};
        run_sc  = 4'(s);
      end
    end
  end

  assign in_ready   = (state == S_IDLE);
  assign out_valid  = (state == S_DONE);
  assign cb_en      = (state == S_RUN) && (cnt < n_q);
  assign cb_addr    = cnt[ADDR_W-1:0];
  assign out_idx    = best_idx;
  assign out_scale  = best_sc;
  assign out_offset = off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      reg_r    <= '0;
      off_q    <= '0;
      n_q      <= '0;
      cnt      <= '0;
      rd_vld   <= 1'b0;
      rd_last  <= 1'b0;
      rd_idx   <= '0;
      best_err <= BW'(ERR_INIT);
      best_idx <= '1;
      best_sc  <= '1;
    end else begin
      case (state)
        S_IDLE: if (in_valid) begin
          state    <= S_RUN;
          off_q    <= off_d;
          n_q      <= n_entries;
          cnt      <= '0;
          rd_vld   <= 1'b0;
          best_err <= BW'(ERR_INIT);
          best_idx <= '1;
          best_sc  <= '1;
          for (int i = 0; i < NPIX; i++)
            reg_r[i] <= DW'({1'b0, in_pix[i*PIX_W +: PIX_W]}) - DW'({1'b0, off_d});
        end
        S_RUN: begin
          rd_vld <= cb_en;
          if (cb_en) begin
            cnt     <= cnt + 1'b1;
            rd_idx  <= cnt[ADDR_W-1:0];
            rd_last <= (cnt + 1'b1 == n_q);
          end
          if (rd_vld) begin
            best_err <= run_err;
            best_idx <= run_idx;
            best_sc  <= run_sc;
          end
          if (n_q == '0 || (rd_vld && rd_last)) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fractal_sad_search_chk.sv
module fractal_sad_search_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              cb_en,
  input logic [ADDR_W-1:0] cb_addr,
  input logic [ADDR_W:0]   out_idx,
  input logic [3:0]        out_scale
);
  a_r9_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r9_ready_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> in_ready);
  a_r9_busy_during_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  a_r7_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !cb_en);
  a_r7_addr_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_en && !$past(cb_en)) |-> cb_addr == '0);
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_en && $past(cb_en)) |-> cb_addr == $past(cb_addr) + 1'b1);
  a_r8_none_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_scale == 4'hF) == (&out_idx)));
endmodule

bind fractal_sad_search fractal_sad_search_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .cb_en(cb_en), .cb_addr(cb_addr), .out_idx(out_idx), .out_scale(out_scale)
);

// File: tb/tb_fractal_sad_search.sv
module tb_fractal_sad_search;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [127:0] in_pix = '0;
  logic [10:0] n_entries = '0;
  logic cb_en;
  logic [9:0] cb_addr;
  logic [143:0] cb_rdata = '0;
  logic out_valid;
  logic [10:0] out_idx;
  logic [3:0] out_scale;
  logic [7:0] out_offset;

  int checks = 0;
  int failures = 0;
  int en_total = 0;
  logic [143:0] cb_mem [1024];
  int px [16];

  always #2.5 clk = ~clk;

  fractal_sad_search dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .n_entries(n_entries), .cb_en(cb_en), .cb_addr(cb_addr),
    .cb_rdata(cb_rdata), .out_valid(out_valid), .out_idx(out_idx),
    .out_scale(out_scale), .out_offset(out_offset));

  always @(posedge clk) begin
    if (cb_en) begin
      cb_rdata <= cb_mem[cb_addr];
      en_total <= en_total + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lane(input int j, input int i);
    return int'($signed(cb_mem[j][i*9 +: 9]));
  endfunction

  function automatic int scaled(input int d, input int s);
    int q4 [8] = '{4, 3, 2, 1, -1, -2, -3, -4};
    return (d * q4[s]) / 4;
  endfunction

  task automatic set_lane(input int j, input int i, input int v);
    cb_mem[j][i*9 +: 9] = 9'(v);
  endtask

  task automatic run_region(input int n, input bit poke, input string what);
    int sum, off, best, e_idx, e_sc, e0, t, d;
    sum = 0;
    for (int i = 0; i < 16; i++) sum += px[i];
    off = sum >> 4;
    best = 8192; e_idx = -1; e_sc = -1;
    for (int j = 0; j < n; j++)
      for (int s = 0; s < 8; s++) begin
        int sad = 0;
        for (int i = 0; i < 16; i++) begin
          d = scaled(lane(j, i), s) - (px[i] - off);
          sad += (d < 0) ? -d : d;
        end
        if (sad > 4095) sad = 4095;
        if (sad < best) begin best = sad; e_idx = j; e_sc = s; end
      end
    @(negedge clk);
    for (int i = 0; i < 16; i++) in_pix[i*8 +: 8] = 8'(px[i]);
    n_entries = 11'(n);
    in_valid = 1'b1;
    e0 = en_total;
    @(negedge clk);
    in_valid = 1'b0;
    if (poke) begin
      in_valid = 1'b1;
      in_pix = {$urandom, $urandom, $urandom, $urandom};
      n_entries = 11'd1;
      @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
    end
    t = 0;
    while (!out_valid && t < 3000) begin @(negedge clk); t++; end
    check(t < 3000, {"R9 result pulse ", what}, t, 3000);
    check(out_offset == 8'(off), {"R2 offset ", what}, out_offset, off);
    check(out_idx == 11'(e_idx), {"R6 index ", what}, out_idx, e_idx);
    check(out_scale == 4'(e_sc), {"R4 scale ", what}, out_scale, e_sc);
    check(en_total - e0 == n, {"R7 read count ", what}, en_total - e0, n);
    @(negedge clk);
    check(!out_valid && in_ready, {"R9 pulse end ", what}, out_valid, 0);
  endtask

  initial begin
    #(5ns * 190000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int j = 0; j < 1024; j++)
      for (int i = 0; i < 16; i++) set_lane(j, i, int'($urandom_range(511)) - 256);
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R1 no pulse after reset", out_valid, 0);
    rst_n = 1'b1;

    // R6 all-zero tie: entry 0, scale 0
    for (int i = 0; i < 16; i++) px[i] = 100;
    for (int j = 0; j < 4; j++) for (int i = 0; i < 16; i++) set_lane(j, i, 0);
    run_region(4, 0, "flat tie");
    check(out_idx == 0 && out_scale == 0, "R6 earliest tie", out_idx, 0);

    // R3 exact match at entry 2
    for (int i = 0; i < 16; i++) px[i] = int'($urandom_range(255));
    begin
      int s = 0;
      for (int i = 0; i < 16; i++) s += px[i];
      for (int i = 0; i < 16; i++) set_lane(2, i, px[i] - (s >> 4));
      for (int i = 0; i < 16; i++) set_lane(5, i, -(px[i] - (s >> 4)));
    end
    run_region(4, 0, "exact entry");
    // R4 negative unit scale at entry 5
    for (int i = 0; i < 16; i++) set_lane(2, i, 200);
    run_region(6, 0, "negated entry");

    // R4 truncation toward zero: lanes of -3 pick code 3, not 4
    for (int i = 0; i < 16; i++) begin px[i] = 50; set_lane(0, i, -3); end
    run_region(1, 0, "truncation");
    check(out_scale == 4'd3, "R4 truncate toward zero", out_scale, 3);

    // R8 empty search
    run_region(0, 0, "empty");
    check(out_idx == 11'h7FF && out_scale == 4'hF, "R8 no match", out_scale, 15);

    // R6 duplicate entry keeps the lower index
    for (int i = 0; i < 16; i++) px[i] = int'($urandom_range(255));
    for (int i = 0; i < 16; i++) set_lane(4, i, lane(1, i));
    run_region(6, 0, "duplicate");

    // R5 saturation region with strong contrast
    for (int i = 0; i < 16; i++) begin
      px[i] = (i % 2) ? 255 : 0;
      set_lane(7, i, (i % 2) ? -256 : 255);
      set_lane(8, i, (i % 2) ? -250 : 250);
    end
    run_region(9, 0, "contrast");

    // R9 in_valid ignored while busy
    for (int i = 0; i < 16; i++) px[i] = int'($urandom_range(255));
    run_region(20, 1, "busy poke");

    // R7 full codebook sweep
    for (int j = 0; j < 16; j++) for (int i = 0; i < 16; i++) set_lane(j, i, int'($urandom_range(511)) - 256);
    run_region(1024, 0, "full sweep");

    for (int r = 0; r < 25; r++) begin
      for (int i = 0; i < 16; i++) px[i] = int'($urandom_range(255));
      run_region(int'($urandom_range(40, 1)), 0, "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule